// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. It drives chip select, the serial clock and the serial data line toward the memory, and it samples the memory's data output. Software-facing logic hands it one command at a time on a valid/ready port: an operation code, an address, write data and a flag that asks for an automatic write-enable. The block frames the instruction, clocks it out and returns one response pulse. A read returns its data with the pulse. Erase and write operations return the pulse only after the memory signals ready, or with a timeout flag if it never does.

The serial clock comes from the system clock. It has a fixed half-period of `HALF_CYC` system cycles, and chip select is held low for `CSL_CYC` cycles before every raise. With the default values of 13 cycles at 50 MHz, each SK phase and each CS-low interval lasts 260 ns. A word-mode input chooses 16-bit words with `AW` address bits, or 8-bit bytes with `AW+1` address bits. Back-pressure on the command port is simple. `cmd_ready` is high only while no operation is in flight, and a command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The response port has no ready: `rsp_valid` is a single-cycle pulse.

Top module: `tweh_host`

## Requirements
- R1: `cmd_ready` is high only while the block is idle, with CS low. Each accepted command yields exactly one `rsp_valid` pulse, one cycle long, after which `cmd_ready` returns high.
- R2: A frame is a 1 start bit, then a 2-bit code, then the address, all sent MSB first. The codes are: read 10, write 01, single-location erase 11, and 00 for the array-wide group. The address field is `AW` bits in word mode and `AW+1` bits in byte mode. Write data follows the address, 16 or 8 bits, MSB first. `cmd_op` encodings: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 and 7 disable.
- R3: SK is high for exactly `HALF_CYC` cycles and low for at least `HALF_CYC` cycles. DI changes only while SK is low, so it is set up and held for one half-period around each rising edge.
- R4: CS is low for at least `CSL_CYC` cycles before every rising edge of CS, including the raise that starts polling.
- R5: For a read, DO is captured at each falling SK edge that follows the last address bit, and the dummy bit during that address bit is discarded. The word or byte is returned on `rsp_data` MSB first. In byte mode bits 15:8 are 0.
- R6: With `cmd_wren` set on a write, erase, erase-all or write-all command, an enable frame (code 00, top address bits 11, rest 0) is sent first. With it clear, no enable frame is sent.
- R7: After the frame of a write, erase, erase-all or write-all, CS is dropped and then raised again. The response is not given until DO is sampled high while CS is high, and CS is dropped with the response.
- R8: If DO stays low for `POLL_LIMIT` cycles of polling, CS is dropped and `rsp_valid` is given together with `rsp_timeout`.
- R9: In the array-wide group, the top two address bits select the operation: 10 for erase-all, 01 for write-all (followed by data), 00 for disable. The remaining address bits are sent as 0.
- R10: After reset, and whenever CS is low, SK and DI are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes; latched per command |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | AW+1 | Location; the top bit is unused in word mode |
| cmd_wdata | input | 16 | Write data; the low byte is used in byte mode |
| cmd_wren | input | 1 | Send an enable frame before a modifying command |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read result, held until the next response |
| rsp_timeout | output | 1 | Set with `rsp_valid` when polling expired |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Serial clock to the memory |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data and ready status from the memory |

## Verification
A wrong bit counter or frame register shows on the memory side in the same frame. The instruction fails to decode, lands at the wrong address, or a read returns shifted data at the next response. A skipped enable frame or a stuck poll state appears as an unchanged memory location, or as a response that arrives before the program cycle has ended. A timer loaded with the wrong value shows in the first SK or CS phase after reset, through phase-length checks that run for every phase of the run. The bench sweeps every address of a small configuration in both widths against a behavioural memory model.

// File: rtl/tweh_pkg.sv
package tweh_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_WRITE_ALL = 3'd4,
    OP_WREN      = 3'd5,
    OP_WRDIS     = 3'd6,
    OP_WRDIS_ALT = 3'd7
  } tweh_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_LO, ST_HI, ST_POLL
  } tweh_state_e;

  function automatic logic op_modifies(tweh_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) ||
           (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
  endfunction
endpackage

// File: rtl/tweh_down_cnt.sv
module tweh_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/tweh_framer.sv
module tweh_framer
  import tweh_pkg::*;
#(
  parameter int AW = 8,
  parameter int FW = AW + 20,
  parameter int CW = 6
) (
  input  tweh_op_e        op,
  input  logic            word,
  input  logic [AW:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [FW-1:0]   frame,
  output logic [CW-1:0]   nbits,
  output logic [CW-1:0]   rdbits
);
  int          af, dw, ntx;
  logic [1:0]  code, sub;
  logic        misc, has_data, is_rd;
  logic [AW:0] amask, afield;
  logic [FW-1:0] val;

  always_comb begin
    af       = word ? AW : AW + 1;
    dw       = word ? WORD_W : BYTE_W;
    code     = 2'b00;
    sub      = 2'b00;
    misc     = 1'b1;
    has_data = 1'b0;
    is_rd    = 1'b0;
    case (op)
      OP_READ:      begin code = 2'b10; misc = 1'b0; is_rd = 1'b1; end
      OP_WRITE:     begin code = 2'b01; misc = 1'b0; has_data = 1'b1; end
      OP_ERASE:     begin code = 2'b11; misc = 1'b0; end
      OP_ERASE_ALL: sub = 2'b10;
      OP_WRITE_ALL: begin sub = 2'b01; has_data = 1'b1; end
      OP_WREN:      sub = 2'b11;
      default:      sub = 2'b00;
    endcase
    amask  = word ? {1'b0, {AW{1'b1}}} : {(AW+1){1'b1}};
    afield = misc ? ((AW+1)'(sub) << (af - 2)) : (addr & amask);
    val    = (FW'({1'b1, code}) << af) | FW'(afield);
    if (has_data)
      val = (val << dw) | FW'(word ? wdata : {8'h00, wdata[7:0]});
    ntx    = 3 + af + (has_data ? dw : 0);
    frame  = val << (FW - ntx);
    nbits  = CW'(ntx + (is_rd ? dw : 0));
    rdbits = CW'(is_rd ? dw : 0);
  end
endmodule

// File: rtl/tweh_host.sv
module tweh_host
  import tweh_pkg::*;
#(
  parameter int AW         = 8,
  parameter int HALF_CYC   = 13,
  parameter int CSL_CYC    = 13,
  parameter int POLL_LIMIT = 600000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [AW:0]       cmd_addr,
  input  logic [15:0]       cmd_wdata,
  input  logic              cmd_wren,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  output logic              rsp_timeout,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int FW   = AW + 20;
  localparam int CW   = $clog2(FW + WORD_W + 1);
  localparam int TMAX = (HALF_CYC > CSL_CYC) ? HALF_CYC : CSL_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_LIMIT + 1);

  tweh_state_e st;
  tweh_op_e    op_in, op_q, fr_op;
  logic [FW-1:0] frm, fr_frame;
  logic [CW-1:0] left, rdn, fr_nbits, fr_rdbits;
  logic [15:0]   shreg, wdata_q, fr_wdata;
  logic [AW:0]   addr_q, fr_addr;
  logic word_q, fr_word, mod_q, pend_main, poll_nxt;
  logic t_load, t_zero, t_csl, p_load, p_zero, last_bit, rd_bit;
  logic [TW-1:0] t_val;

  assign op_in     = tweh_op_e'(cmd_op);
  assign cmd_ready = (st == ST_IDLE);
  assign last_bit  = (left == CW'(1));
  assign rd_bit    = (left <= rdn);

  // frame source: the incoming command while idle, else the latched one
  always_comb begin
    if (st == ST_IDLE) begin
      fr_op    = (cmd_wren && op_modifies(op_in)) ? OP_WREN : op_in;
      fr_word  = word_mode;
      fr_addr  = cmd_addr;
      fr_wdata = cmd_wdata;
    end else begin
      fr_op    = op_q;
      fr_word  = word_q;
      fr_addr  = addr_q;
      fr_wdata = wdata_q;
    end
  end

  tweh_framer #(.AW(AW), .FW(FW), .CW(CW)) u_framer (
    .op(fr_op), .word(fr_word), .addr(fr_addr), .wdata(fr_wdata),
    .frame(fr_frame), .nbits(fr_nbits), .rdbits(fr_rdbits)
  );

  // phase timer: SK half-periods and CS-low gaps
  always_comb begin
    t_csl  = (st == ST_IDLE) || (st == ST_HI && last_bit);
    t_val  = t_csl ? TW'(CSL_CYC - 1) : TW'(HALF_CYC - 1);
    t_load = (st == ST_IDLE && cmd_valid) ||
             (st == ST_GAP  && t_zero && !poll_nxt) ||
             (st == ST_LO   && t_zero) ||
             (st == ST_HI   && t_zero && (!last_bit || pend_main || mod_q));
    p_load = (st == ST_GAP && t_zero && poll_nxt);
  end

  tweh_down_cnt #(.W(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  tweh_down_cnt #(.W(PW)) u_poll (
    .clk(clk), .rst_n(rst_n), .load(p_load),
    .load_val(PW'(POLL_LIMIT - 1)), .zero(p_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cs_o <= 1'b0; sk_o <= 1'b0; di_o <= 1'b0;
      frm <= '0; left <= '0; rdn <= '0; shreg <= '0;
      op_q <= OP_READ; word_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
      mod_q <= 1'b0; pend_main <= 1'b0; poll_nxt <= 1'b0;
      rsp_valid <= 1'b0; rsp_timeout <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      rsp_timeout <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q      <= op_in;
          word_q    <= word_mode;
          addr_q    <= cmd_addr;
          wdata_q   <= cmd_wdata;
          mod_q     <= op_modifies(op_in);
          pend_main <= cmd_wren && op_modifies(op_in);
          poll_nxt  <= 1'b0;
          frm       <= fr_frame;
          left      <= fr_nbits;
          rdn       <= fr_rdbits;
          shreg     <= '0;
          st        <= ST_GAP;
        end
        ST_GAP: if (t_zero) begin
          cs_o <= 1'b1;
          if (poll_nxt) begin
            poll_nxt <= 1'b0;
            st       <= ST_POLL;
          end else begin
            di_o <= frm[FW-1];
            st   <= ST_LO;
          end
        end
        ST_LO: if (t_zero) begin
          sk_o <= 1'b1;
          st   <= ST_HI;
        end
        ST_HI: if (t_zero) begin
          sk_o <= 1'b0;
          if (rd_bit) shreg <= {shreg[14:0], do_i};
          if (last_bit) begin
            cs_o <= 1'b0;
            di_o <= 1'b0;
            if (pend_main) begin
              pend_main <= 1'b0;
              frm       <= fr_frame;
              left      <= fr_nbits;
              rdn       <= fr_rdbits;
              st        <= ST_GAP;
            end else if (mod_q) begin
              poll_nxt <= 1'b1;
              st       <= ST_GAP;
            end else begin
              rsp_valid <= 1'b1;
              rsp_data  <= (rdn != '0) ? {shreg[14:0], do_i} : 16'h0000;
              st        <= ST_IDLE;
            end
          end else begin
            frm  <= frm << 1;
            di_o <= frm[FW-2];
            left <= left - 1'b1;
            st   <= ST_LO;
          end
        end
        ST_POLL: begin
          if (do_i || p_zero) begin
            cs_o        <= 1'b0;
            rsp_valid   <= 1'b1;
            rsp_timeout <= !do_i;
            rsp_data    <= 16'h0000;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // run-length trackers used by the timing assertions
  logic [15:0] hi_run, lo_run, csl_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0; lo_run <= '0; csl_run <= '0;
    end else begin
      hi_run  <= sk_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : 16'h0;
      lo_run  <= !sk_o ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : 16'h0;
      csl_run <= !cs_o ? ((csl_run == 16'hFFFF) ? csl_run : csl_run + 1'b1) : 16'h0;
    end
  end

  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !cs_o);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r3_di_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o |-> $stable(di_o));
  a_r3_sk_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sk_o) |-> (hi_run == 16'(HALF_CYC)));
  a_r3_sk_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk_o) |-> (lo_run >= 16'(HALF_CYC)));
  a_r4_cs_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> (csl_run >= 16'(CSL_CYC)));
  a_r8_timeout_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> rsp_valid);
  a_r10_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_o |-> (!sk_o && !di_o));
endmodule

// File: tb/test_tweh_host.sv
module test_tweh_host;
  localparam int AW = 4, HALF = 2, CSL = 3, PLIM = 60, BUSY = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_mode = 1'b1, cmd_valid = 1'b0, cmd_wren = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [AW:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_timeout, cs_o, sk_o, di_o, do_i;
  logic [15:0] rsp_data;

  int total = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  tweh_host #(.AW(AW), .HALF_CYC(HALF), .CSL_CYC(CSL), .POLL_LIMIT(PLIM)) i_tweh_host (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_wren(cmd_wren), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_timeout(rsp_timeout), .cs_o(cs_o),
    .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
  );

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [32];
  logic ewen, stuck = 1'b0, do_r, rd_mode, sk_p, cs_p;
  int busy_cnt, bc;
  logic [63:0] ish;
  logic [15:0] rd_sh;

  assign do_i = (cs_o && bc == 0) ? !(stuck || busy_cnt != 0) : do_r;

  function automatic logic [7:0] gb(int a);
    return 8'h96 ^ 8'(a * 29);
  endfunction
  function automatic logic [15:0] fw(int a);
    return 16'h3C5A ^ 16'(a * 16'h0911);
  endfunction

  always @(negedge clk) begin : model
    int af, dw, a, d, op, sub;
    af = word_mode ? AW : AW + 1;
    dw = word_mode ? 16 : 8;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] = 8'h00;
      ewen = 1'b0; busy_cnt = 0; bc = 0; ish = '0; do_r = 1'b0;
      rd_mode = 1'b0; sk_p = 1'b0; cs_p = 1'b0; rd_sh = '0;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      if (cs_p && !cs_o) begin
        op = -1; a = 0; d = 0;
        if (bc == 3 + af) begin
          op = int'((ish >> af) & 64'd3); a = int'(ish & ((64'd1 << af) - 1));
        end else if (bc == 3 + af + dw) begin
          d = int'(ish & ((64'd1 << dw) - 1));
          a = int'((ish >> dw) & ((64'd1 << af) - 1));
          op = int'((ish >> (dw + af)) & 64'd3) + 4;
        end
        sub = a >> (af - 2);
        if (op == 0 && sub == 3) ewen = 1'b1;
        else if (op == 0 && sub == 0) ewen = 1'b0;
        else if (ewen && op == 0 && sub == 2) begin
          for (int i = 0; i < 32; i++) mem[i] = 8'hFF;
          busy_cnt = BUSY;
        end else if (ewen && op == 4 && sub == 1) begin
          for (int i = 0; i < 32; i++) mem[i] = (word_mode && i[0]) ? 8'(d >> 8) : 8'(d);
          busy_cnt = BUSY;
        end else if (ewen && (op == 5 || op == 3)) begin
          if (op == 3) d = 32'hFFFF;
          if (word_mode) begin mem[2*a] = 8'(d); mem[2*a+1] = 8'(d >> 8); end
          else mem[a] = 8'(d);
          busy_cnt = BUSY;
        end
        bc = 0; ish = '0; do_r = 1'b0; rd_mode = 1'b0;
      end else if (cs_o && sk_o && !sk_p && (bc != 0 || di_o)) begin
        ish = {ish[62:0], di_o};
        bc++;
        if (bc == 3 + af && ((ish >> af) & 64'd3) == 64'd2) begin
          a = int'(ish & ((64'd1 << af) - 1));
          rd_sh = word_mode ? {mem[2*a+1], mem[2*a]} : {mem[a], 8'h00};
          rd_mode = 1'b1;
          do_r = 1'b0;
        end else if (rd_mode) begin
          do_r = rd_sh[15];
          rd_sh = rd_sh << 1;
        end
      end
      sk_p = sk_o; cs_p = cs_o;
    end
  end

  // ---------------- port-level timing monitor ----------------
  int min_hi = 1000, min_lo = 1000, min_csl = 1000, sk_run = 0, cs_run = 0;
  int di_viol = 0, idle_viol = 0;
  logic skb = 1'b0, csb = 1'b0, dib = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (sk_o && skb && di_o != dib) di_viol++;
    if (!cs_o && (sk_o || di_o)) idle_viol++;
    if (sk_o != skb) begin
      if (skb) min_hi = (sk_run < min_hi) ? sk_run : min_hi;
      else     min_lo = (sk_run < min_lo) ? sk_run : min_lo;
      sk_run = 1;
    end else sk_run++;
    if (cs_o && !csb) min_csl = (cs_run < min_csl) ? cs_run : min_csl;
    cs_run = cs_o ? 0 : cs_run + 1;
    skb = sk_o; csb = cs_o; dib = di_o;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_up();
    end
  end

  int lat;
  task automatic run(input int op, input int addr, input int data, input logic wren,
                     output logic [15:0] rd, output logic to);
    @(negedge clk);
    cmd_op = 3'(op); cmd_addr = (AW+1)'(addr); cmd_wdata = 16'(data);
    cmd_wren = wren; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    if (cmd_ready) chk(1'b0, "R1 ready after accept", 1, 0);
    while (!rsp_valid && lat < 5000) begin @(negedge clk); lat++; end
    rd = rsp_data; to = rsp_timeout;
    chk(rsp_valid, "R1 response pulse", int'(rsp_valid), 1);
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R1 single pulse then ready",
        int'({rsp_valid, cmd_ready}), 1);
  endtask

  logic [15:0] rd;
  logic to;
  initial begin
    repeat (4) @(negedge clk);
    chk(cmd_ready && !cs_o && !sk_o && !di_o && !rsp_valid, "R10 reset state",
        int'({cmd_ready, cs_o, sk_o, di_o, rsp_valid}), 16);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // word mode: program every word with the automatic enable
    word_mode = 1'b1;
    for (int a = 0; a < 16; a++) begin
      run(1, a, int'(fw(a)), 1'b1, rd, to);
      chk(!to && busy_cnt == 0, "R7 done only after ready", busy_cnt, 0);
    end
    for (int a = 0; a < 16; a++)
      chk({mem[2*a+1], mem[2*a]} == fw(a), "R2 R6 word frame stored",
          int'({mem[2*a+1], mem[2*a]}), int'(fw(a)));
    for (int a = 0; a < 16; a++) begin
      run(0, a, 0, 1'b0, rd, to);
      chk(rd == fw(a), "R5 word read", int'(rd), int'(fw(a)));
    end

    // disable, then a write without enable prefix must not land
    run(6, 0, 0, 1'b0, rd, to);
    run(1, 3, 16'h1234, 1'b0, rd, to);
    run(0, 3, 0, 1'b0, rd, to);
    chk(rd == fw(3), "R6 no prefix when flag clear", int'(rd), int'(fw(3)));
    run(5, 0, 0, 1'b0, rd, to);
    run(1, 3, 16'h1234, 1'b0, rd, to);
    run(0, 3, 0, 1'b0, rd, to);
    chk(rd == 16'h1234, "R2 explicit enable then write", int'(rd), 16'h1234);
    run(2, 5, 0, 1'b1, rd, to);
    run(0, 5, 0, 1'b0, rd, to);
    chk(rd == 16'hFFFF, "R2 erase code", int'(rd), 16'hFFFF);

    // byte mode: every byte address
    word_mode = 1'b0;
    for (int a = 0; a < 32; a++) run(1, a, {8'hC3, gb(a)}, 1'b1, rd, to);
    for (int a = 0; a < 32; a++) begin
      run(0, a, 0, 1'b0, rd, to);
      chk(rd == {8'h00, gb(a)}, "R5 byte read upper zero", int'(rd), int'(gb(a)));
    end

    // array-wide operations
    run(3, 0, 0, 1'b1, rd, to);
    for (int a = 0; a < 32; a += 7)
      chk(mem[a] == 8'hFF, "R9 erase all", int'(mem[a]), 8'hFF);
    run(4, 0, 16'h005A, 1'b1, rd, to);
    run(0, 31, 0, 1'b0, rd, to);
    chk(rd == 16'h005A, "R9 write all byte", int'(rd), 16'h005A);
    word_mode = 1'b1;
    run(4, 0, 16'hBEEF, 1'b1, rd, to);
    for (int a = 0; a < 16; a += 5) begin
      run(0, a, 0, 1'b0, rd, to);
      chk(rd == 16'hBEEF, "R9 write all word", int'(rd), 16'hBEEF);
    end

    // polling timeout
    stuck = 1'b1;
    run(1, 2, 16'h0F0F, 1'b1, rd, to);
    chk(to == 1'b1, "R8 timeout flagged", int'(to), 1);
    chk(lat >= PLIM, "R8 not before limit", lat, PLIM);
    chk(!cs_o, "R8 CS dropped", int'(cs_o), 0);
    stuck = 1'b0;
    run(0, 7, 0, 1'b0, rd, to);
    chk(rd == 16'hBEEF && !to, "R8 recovery read", int'(rd), 16'hBEEF);

    chk(min_hi == HALF, "R3 SK high length", min_hi, HALF);
    chk(min_lo >= HALF, "R3 SK low length", min_lo, HALF);
    chk(di_viol == 0, "R3 DI stable while SK high", di_viol, 0);
    chk(min_csl >= CSL, "R4 CS low length", min_csl, CSL);
    chk(idle_viol == 0, "R10 SK DI low while CS low", idle_viol, 0);
    finish_up();
  end
endmodule